// File: doc/BRIEF.md
# Dual-Clock FIFO with Loadable Almost-Empty and Almost-Full Thresholds

This block is a 1024-entry, 9-bit-wide first-in first-out buffer whose write port and read port run on two unrelated clocks. Each side keeps its own binary pointer. Each pointer is turned into gray code and passed through a two-stage synchroniser to the other side. Each side then computes the fill level from its own pointer and the synchronised copy of the other pointer.

Two threshold flags, both active low, are driven from that fill level. The almost-empty flag sits in the read clock domain and the almost-full flag sits in the write clock domain. Their thresholds are two 10-bit offsets. Each offset is split over a low register and a high register. Software loads these registers through the write data port while a configuration strobe is held low, and reads them back through the read data port the same way. Each access moves to the next register in a fixed cycle of four.

Top module: `afifo_pflag`

## Requirements
- R1: With `cfg_ni` high and `wr_req_ni` low, each rising `wclk_i` edge stores `wdata_i` if the FIFO is not full. With `cfg_ni` high and both read requests low, each rising `rclk_i` edge puts the oldest unread word on `rdata_o`, so words leave in the order they were written. Pointers cross between the domains in gray code, so a pointer changes by at most one bit per clock.
- R2: While `wr_req_ni` is high, nothing is written on a `wclk_i` edge, neither to the FIFO nor to an offset register, whatever `cfg_ni` is.
- R3: A write attempted while the FIFO holds 1024 words is dropped, and the stored contents and count are unchanged.
- R4: A FIFO read happens only when both `rd_a_ni` and `rd_b_ni` are low. A read while empty, or with only one request low, leaves the read pointer unchanged and holds `rdata_o`.
- R5: With `cfg_ni` low and `wr_req_ni` low, each `wclk_i` edge writes `wdata_i` into one offset register, stepping through this cycle: empty-low, empty-high, full-low, full-high, then back to empty-low. A low register holds offset bits 8..0 from `wdata_i[8:0]`. A high register holds offset bit 9 from `wdata_i[0]`.
- R6: With `cfg_ni` low and both read requests low, each `rclk_i` edge puts the next offset register on `rdata_o`, in the same four-step cycle as R5. A high register reads back with bits 8..1 as zero. Readback does not move the FIFO read pointer.
- R7: `almost_empty_no` is registered on `rclk_i`. It is low when the FIFO holds n or fewer words and high when it holds n+1 or more, where n is the empty offset.
- R8: `almost_full_no` is registered on `wclk_i`. It is low when the FIFO holds at least 1024 - m words and high otherwise, where m is the full offset.
- R9: While `rst_ni` is low, both offsets are 7, both pointers and both register-select counters are cleared, `rdata_o` is 0, `almost_empty_no` is low and `almost_full_no` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock, asynchronous to `wclk_i` |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_req_ni | input | 1 | Write request, active low |
| cfg_ni | input | 1 | Low selects the offset registers instead of the FIFO |
| wdata_i | input | 9 | Write data or offset value |
| rd_a_ni | input | 1 | First read request, active low |
| rd_b_ni | input | 1 | Second read request, active low |
| rdata_o | output | 9 | Read data or offset readback |
| almost_empty_no | output | 1 | Low when the fill level is at most the empty offset |
| almost_full_no | output | 1 | Low when free space is at most the full offset |

## Verification
A select counter that slips shows up on the very next readback, as the wrong register value, and from then on every load lands in the wrong field. A pointer that moves on an ignored write or read shows up as a missing or duplicated word when the FIFO is drained. It also leaves both flags wrong by one entry, visible within a few clocks once the synchronisers settle. The bench fills the FIFO one word at a time to 1024 and then drains it one word at a time, checking both flags after every step. An error in a threshold comparison or in offset assembly therefore shows up at the exact fill level where it first matters.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  typedef enum logic [1:0] {
    SEL_AE_LO = 2'd0,
    SEL_AE_HI = 2'd1,
    SEL_AF_LO = 2'd2,
    SEL_AF_HI = 2'd3
  } ofs_sel_e;
endpackage

// File: rtl/afifo_ram.sv
module afifo_ram #(
  parameter int DW = 9,
  parameter int AW = 10
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // read port is combinational; the read controller registers it
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/afifo_gray_sync.sv
module afifo_gray_sync #(
  parameter int W = 11
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] gray_i,
  output logic [W-1:0] bin_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= gray_i;
      s2_q <= s1_q;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) bin_o[i] = ^(s2_q >> i);
  end
endmodule

// File: rtl/afifo_wr_ctrl.sv
module afifo_wr_ctrl
  import afifo_pkg::*;
#(
  parameter int DW      = 9,
  parameter int AW      = 10,
  parameter int OFS_DEF = 7
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wr_req_ni,
  input  logic          cfg_ni,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW:0]   rbin_sync_i,
  output logic [AW:0]   wbin_o,
  output logic [AW:0]   wgray_o,
  output logic          full_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW-1:0] ae_ofs_o,
  output logic [AW-1:0] af_ofs_o,
  output ofs_sel_e      ld_sel_o,
  output logic          almost_full_no
);
  localparam int PW   = AW + 1;
  localparam int LO_W = (AW < DW) ? AW : DW;
  localparam int HI_W = AW - LO_W;
  localparam logic [AW-1:0] LO_MASK = {AW{1'b1}} >> HI_W;
  localparam logic [PW-1:0] DEPTH_P = PW'(1) << AW;

  logic [AW:0]   wbin_q, wbin_nxt, wgray_q, cnt_nxt, af_thr;
  logic [AW-1:0] ae_ofs_q, af_ofs_q, lo_val, hi_val;
  ofs_sel_e      sel_q;
  logic          wr_do, ld_do, af_n_q;

  assign full_o   = (wbin_q - rbin_sync_i) == DEPTH_P;
  assign wr_do    = !wr_req_ni && cfg_ni && !full_o;
  assign ld_do    = !wr_req_ni && !cfg_ni;
  assign wbin_nxt = wbin_q + PW'(wr_do);
  assign cnt_nxt  = wbin_nxt - rbin_sync_i;
  assign af_thr   = DEPTH_P - PW'(af_ofs_q);

  assign lo_val = AW'(wdata_i) & LO_MASK;
  assign hi_val = (AW'(wdata_i) << LO_W) & ~LO_MASK;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      af_n_q  <= 1'b1;
    end else begin
      wbin_q  <= wbin_nxt;
      wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
      af_n_q  <= !(cnt_nxt >= af_thr);
    end
  end

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ae_ofs_q <= AW'(OFS_DEF);
      af_ofs_q <= AW'(OFS_DEF);
      sel_q    <= SEL_AE_LO;
    end else if (ld_do) begin
      unique case (sel_q)
        SEL_AE_LO: ae_ofs_q <= (ae_ofs_q & ~LO_MASK) | lo_val;
        SEL_AE_HI: ae_ofs_q <= (ae_ofs_q & LO_MASK) | hi_val;
        SEL_AF_LO: af_ofs_q <= (af_ofs_q & ~LO_MASK) | lo_val;
        SEL_AF_HI: af_ofs_q <= (af_ofs_q & LO_MASK) | hi_val;
        default: ;
      endcase
      sel_q <= ofs_sel_e'(sel_q + 2'd1);
    end
  end

  assign wbin_o         = wbin_q;
  assign wgray_o        = wgray_q;
  assign we_o           = wr_do;
  assign waddr_o        = wbin_q[AW-1:0];
  assign ae_ofs_o       = ae_ofs_q;
  assign af_ofs_o       = af_ofs_q;
  assign ld_sel_o       = sel_q;
  assign almost_full_no = af_n_q;
endmodule

// File: rtl/afifo_rd_ctrl.sv
module afifo_rd_ctrl
  import afifo_pkg::*;
#(
  parameter int DW = 9,
  parameter int AW = 10
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          rd_a_ni,
  input  logic          rd_b_ni,
  input  logic          cfg_ni,
  input  logic [AW:0]   wbin_sync_i,
  input  logic [DW-1:0] ram_rdata_i,
  input  logic [AW-1:0] ae_ofs_i,
  input  logic [AW-1:0] af_ofs_i,
  output logic [AW:0]   rbin_o,
  output logic [AW:0]   rgray_o,
  output logic [AW-1:0] raddr_o,
  output logic          empty_o,
  output logic [DW-1:0] rdata_o,
  output logic          almost_empty_no
);
  localparam int PW   = AW + 1;
  localparam int LO_W = (AW < DW) ? AW : DW;
  localparam int HI_W = AW - LO_W;
  localparam logic [AW-1:0] LO_MASK = {AW{1'b1}} >> HI_W;

  logic [AW:0]   rbin_q, rbin_nxt, rgray_q, cnt_nxt;
  logic [DW-1:0] rdata_q, rb_val;
  ofs_sel_e      sel_q;
  logic          rd_en, rd_do, rb_do, ae_n_q;

  assign empty_o  = (rbin_q == wbin_sync_i);
  assign rd_en    = !rd_a_ni && !rd_b_ni;
  assign rd_do    = rd_en && cfg_ni && !empty_o;
  assign rb_do    = rd_en && !cfg_ni;
  assign rbin_nxt = rbin_q + PW'(rd_do);
  assign cnt_nxt  = wbin_sync_i - rbin_nxt;

  always_comb begin
    unique case (sel_q)
      SEL_AE_LO: rb_val = DW'(ae_ofs_i & LO_MASK);
      SEL_AE_HI: rb_val = DW'(ae_ofs_i >> LO_W);
      SEL_AF_LO: rb_val = DW'(af_ofs_i & LO_MASK);
      SEL_AF_HI: rb_val = DW'(af_ofs_i >> LO_W);
      default:   rb_val = '0;
    endcase
  end

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      ae_n_q  <= 1'b0;
      rdata_q <= '0;
      sel_q   <= SEL_AE_LO;
    end else begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
      ae_n_q  <= cnt_nxt > PW'(ae_ofs_i);
      if (rd_do) rdata_q <= ram_rdata_i;
      else if (rb_do) rdata_q <= rb_val;
      if (rb_do) sel_q <= ofs_sel_e'(sel_q + 2'd1);
    end
  end

  assign rbin_o          = rbin_q;
  assign rgray_o         = rgray_q;
  assign raddr_o         = rbin_q[AW-1:0];
  assign rdata_o         = rdata_q;
  assign almost_empty_no = ae_n_q;
endmodule

// File: rtl/afifo_pflag.sv
module afifo_pflag
  import afifo_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int ADDR_W  = 10,
  parameter int OFS_DEF = 7
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_req_ni,
  input  logic              cfg_ni,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_a_ni,
  input  logic              rd_b_ni,
  output logic [DATA_W-1:0] rdata_o,
  output logic              almost_empty_no,
  output logic              almost_full_no
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0]     wbin, wgray, rbin, rgray, wbin_sync, rbin_sync;
  logic [ADDR_W-1:0] waddr, raddr, ae_ofs, af_ofs;
  logic [DATA_W-1:0] ram_rdata;
  logic              full, empty, we;
  ofs_sel_e          ld_sel;

  afifo_wr_ctrl #(.DW(DATA_W), .AW(ADDR_W), .OFS_DEF(OFS_DEF)) u_wr (
    .wclk_i         (wclk_i),
    .rst_ni         (rst_ni),
    .wr_req_ni      (wr_req_ni),
    .cfg_ni         (cfg_ni),
    .wdata_i        (wdata_i),
    .rbin_sync_i    (rbin_sync),
    .wbin_o         (wbin),
    .wgray_o        (wgray),
    .full_o         (full),
    .we_o           (we),
    .waddr_o        (waddr),
    .ae_ofs_o       (ae_ofs),
    .af_ofs_o       (af_ofs),
    .ld_sel_o       (ld_sel),
    .almost_full_no (almost_full_no)
  );

  afifo_ram #(.DW(DATA_W), .AW(ADDR_W)) u_ram (
    .wclk_i  (wclk_i),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata_i),
    .raddr_i (raddr),
    .rdata_o (ram_rdata)
  );

  afifo_gray_sync #(.W(PW)) u_sync_w2r (
    .clk_i  (rclk_i),
    .rst_ni (rst_ni),
    .gray_i (wgray),
    .bin_o  (wbin_sync)
  );

  afifo_gray_sync #(.W(PW)) u_sync_r2w (
    .clk_i  (wclk_i),
    .rst_ni (rst_ni),
    .gray_i (rgray),
    .bin_o  (rbin_sync)
  );

  afifo_rd_ctrl #(.DW(DATA_W), .AW(ADDR_W)) u_rd (
    .rclk_i          (rclk_i),
    .rst_ni          (rst_ni),
    .rd_a_ni         (rd_a_ni),
    .rd_b_ni         (rd_b_ni),
    .cfg_ni          (cfg_ni),
    .wbin_sync_i     (wbin_sync),
    .ram_rdata_i     (ram_rdata),
    .ae_ofs_i        (ae_ofs),
    .af_ofs_i        (af_ofs),
    .rbin_o          (rbin),
    .rgray_o         (rgray),
    .raddr_o         (raddr),
    .empty_o         (empty),
    .rdata_o         (rdata_o),
    .almost_empty_no (almost_empty_no)
  );
endmodule

// File: rtl/afifo_pflag_chk.sv
module afifo_pflag_chk #(
  parameter int DW = 9,
  parameter int AW = 10
) (
  input logic          wclk_i,
  input logic          rclk_i,
  input logic          rst_ni,
  input logic          wr_req_ni,
  input logic          cfg_ni,
  input logic          rd_a_ni,
  input logic          rd_b_ni,
  input logic          full_i,
  input logic          empty_i,
  input logic [AW:0]   wbin_i,
  input logic [AW:0]   rbin_i,
  input logic [AW:0]   wgray_i,
  input logic [AW:0]   rgray_i,
  input logic [1:0]    ld_sel_i,
  input logic [DW-1:0] rdata_i
);
  p_wgray_step_r1: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(wgray_i ^ $past(wgray_i)) <= 1);

  p_rgray_step_r1: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(rgray_i ^ $past(rgray_i)) <= 1);

  p_wr_idle_r2: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    wr_req_ni |=> ($stable(wbin_i) && $stable(ld_sel_i)));

  p_no_overflow_r3: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wr_req_ni && full_i) |=> $stable(wbin_i));

  p_no_underflow_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (!rd_a_ni && !rd_b_ni && empty_i) |=> $stable(rbin_i));

  p_single_req_r4: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (rd_a_ni || rd_b_ni) |=> ($stable(rbin_i) && $stable(rdata_i)));

  p_ld_order_r5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (!wr_req_ni && !cfg_ni) |=> (ld_sel_i == 2'($past(ld_sel_i) + 2'd1)));

  p_rb_keeps_ptr_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !cfg_ni |=> $stable(rbin_i));
endmodule

bind afifo_pflag afifo_pflag_chk #(.DW(DATA_W), .AW(ADDR_W)) u_chk (
  .wclk_i    (wclk_i),
  .rclk_i    (rclk_i),
  .rst_ni    (rst_ni),
  .wr_req_ni (wr_req_ni),
  .cfg_ni    (cfg_ni),
  .rd_a_ni   (rd_a_ni),
  .rd_b_ni   (rd_b_ni),
  .full_i    (full),
  .empty_i   (empty),
  .wbin_i    (wbin),
  .rbin_i    (rbin),
  .wgray_i   (wgray),
  .rgray_i   (rgray),
  .ld_sel_i  (ld_sel),
  .rdata_i   (rdata_o)
);

// File: tb/afifo_pflag_test.sv
`timescale 1ns/1ps
module afifo_pflag_test;
  localparam int DEPTH = 1024;

  logic       wclk = 0, rclk = 0, rst_n = 0;
  logic       wr_req_n = 1, cfg_n = 1, rd_a_n = 1, rd_b_n = 1;
  logic [8:0] wdata = '0;
  logic [8:0] rdata;
  logic       ae_n, af_n;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2 wclk = ~wclk;
  always #3 rclk = ~rclk;

  afifo_pflag uut (
    .wclk_i          (wclk),
    .rclk_i          (rclk),
    .rst_ni          (rst_n),
    .wr_req_ni       (wr_req_n),
    .cfg_ni          (cfg_n),
    .wdata_i         (wdata),
    .rd_a_ni         (rd_a_n),
    .rd_b_ni         (rd_b_n),
    .rdata_o         (rdata),
    .almost_empty_no (ae_n),
    .almost_full_no  (af_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [8:0] d);
    @(negedge wclk);
    wr_req_n = 0;
    wdata = d;
    @(posedge wclk);
    #1 wr_req_n = 1;
  endtask

  task automatic rd(output logic [8:0] q);
    @(negedge rclk);
    rd_a_n = 0;
    rd_b_n = 0;
    @(posedge rclk);
    #1;
    rd_a_n = 1;
    rd_b_n = 1;
    q = rdata;
  endtask

  task automatic settle();
    repeat (10) @(posedge rclk);
    repeat (4) @(posedge wclk);
    #1;
  endtask

  function automatic logic [8:0] pat(input int k);
    return 9'((k * 37) & 9'h1ff);
  endfunction

  initial begin
    #700000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (run incomplete)");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [8:0] q;
    int n_ofs, m_ofs;

    // R9 reset state
    repeat (3) @(posedge wclk);
    #1;
    chk("R9 ae_n reset", ae_n, 0);
    chk("R9 af_n reset", af_n, 1);
    chk("R9 rdata reset", rdata, 0);
    @(negedge wclk);
    rst_n = 1;
    settle();
    chk("R9 ae_n after release", ae_n, 0);
    chk("R9 af_n after release", af_n, 1);

    // R6/R9 default offsets read back: 7, 0, 7, 0
    cfg_n = 0;
    for (int i = 0; i < 4; i++) begin
      rd(q);
      chk("R9 default offset readback", q, (i % 2 == 0) ? 7 : 0);
    end
    cfg_n = 1;

    // R7 with default n = 7
    for (int k = 1; k <= 8; k++) begin
      wr(9'(100 + k));
      settle();
      chk("R7 default threshold ae_n", ae_n, (k > 7) ? 1 : 0);
    end
    for (int k = 1; k <= 8; k++) begin
      rd(q);
      chk("R1 order after default fill", q, 100 + k);
    end
    settle();
    chk("R7 ae_n after drain", ae_n, 0);

    // R5 load: n = 520 (lo 0x008, hi bit0 = 1), m = 600 (lo 0x058, hi bit0 = 1)
    cfg_n = 0;
    wr(9'h008);
    // R2 idle cycle with cfg low and a stray value
    @(negedge wclk);
    wdata = 9'h1aa;
    @(posedge wclk);
    wr(9'h1ff);
    wr(9'h058);
    wr(9'h003);
    n_ofs = 520;
    m_ofs = 600;
    settle();
    for (int i = 0; i < 5; i++) begin
      int e;
      rd(q);
      case (i % 4)
        0: e = 9'h008;
        1: e = 1;
        2: e = 9'h058;
        default: e = 1;
      endcase
      chk("R5/R6 offset readback", q, e);
    end
    for (int i = 0; i < 3; i++) rd(q);
    cfg_n = 1;
    settle();

    // R4 FIFO read while empty holds output (last readback was full-high = 1)
    rd(q);
    chk("R4 read while empty holds rdata", q, 1);

    // R7/R8 fill sweep
    for (int k = 1; k <= DEPTH; k++) begin
      wr(pat(k));
      settle();
      chk("R7 fill ae_n", ae_n, (k > n_ofs) ? 1 : 0);
      chk("R8 fill af_n", af_n, (k >= DEPTH - m_ofs) ? 0 : 1);
    end

    // R3 write while full dropped
    wr(9'h155);
    settle();
    chk("R3 af_n stays low when full", af_n, 0);

    // R6 readback mid-stream does not disturb the FIFO read pointer
    cfg_n = 0;
    for (int i = 0; i < 4; i++) begin
      rd(q);
      chk("R6 readback while full", q, (i == 0) ? 9'h008 : (i == 2) ? 9'h058 : 1);
    end
    cfg_n = 1;

    // R1 drain sweep with flags
    for (int j = 1; j <= DEPTH; j++) begin
      rd(q);
      chk("R1 drain data order", q, pat(j));
      settle();
      chk("R7 drain ae_n", ae_n, ((DEPTH - j) > n_ofs) ? 1 : 0);
      chk("R8 drain af_n", af_n, ((DEPTH - j) >= DEPTH - m_ofs) ? 0 : 1);
    end

    // R4 underflow: output holds, pointer unchanged
    rd(q);
    chk("R4 underflow holds rdata", q, pat(DEPTH));
    wr(9'h0aa);
    settle();
    rd(q);
    chk("R4 first word after underflow", q, 9'h0aa);

    // R2 stray data with write request high
    @(negedge wclk);
    wdata = 9'h077;
    repeat (2) @(posedge wclk);
    wr(9'h0bb);
    settle();

    // R4 one request alone does not read
    @(negedge rclk);
    rd_a_n = 0;
    @(posedge rclk);
    #1 rd_a_n = 1;
    chk("R4 single request no read", rdata, 9'h0aa);
    @(negedge rclk);
    rd_b_n = 0;
    @(posedge rclk);
    #1 rd_b_n = 1;
    chk("R4 other single request no read", rdata, 9'h0aa);
    rd(q);
    chk("R1 queued word", q, 9'h0bb);
    rd(q);
    chk("R2 no stray word stored", q, 9'h0bb);
    settle();
    chk("R7 empty at end", ae_n, 0);
    chk("R8 af_n at end", af_n, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule